// File: doc/BRIEF.md
# Host Bridge Configuration Register Space

This block holds the 256-byte configuration space of a host bridge. The space is organised as one byte per 8-bit offset. Software reaches it through a plain byte port: a function number, an offset, a write enable with write data, and read data that follows the addressed byte combinationally. Only function 0 is implemented.

Each offset has its own write rule. The identity bytes and several other ranges are read-only. The command byte accepts a change to one bit only. The upper status byte clears bits when they are written as 1. Every remaining byte stores whatever is written to it.

The three memory-shadowing control bytes are driven out as ports for a downstream address decoder. A one-cycle pulse marks any cycle in which one of these bytes took a new value, so cached mappings can be invalidated. A separate bridge-reset event input forces the two system-BIOS shadow bits of the third control byte to zero.

Top module: `hb_cfg_space`

## Requirements
- R1: After reset, reading offsets 0x00, 0x01, 0x02 and 0x03 returns 0x06, 0x11, 0x85 and 0x05. Offset 0x04 returns 0x07, offsets 0x06 and 0x07 return 0xA0 and 0x02, and offset 0x0B returns 0x06.
- R2: After reset, offset 0x58 returns 0x40 and 0x59 returns 0x05. Offsets 0x5A through 0x5F each return 0x01, offset 0x64 returns 0xAB, and every other offset returns 0x00.
- R3: A write has no effect on these offsets: 0x00-0x03, 0x05-0x06, 0x08-0x0C, 0x0E-0x11, 0x14-0x4F, 0x79-0x7D, 0x85-0x87, 0x8C-0xA7 and 0xAD-0xFC.
- R4: A write to offset 0x04 replaces bit 6 only. Bits 7 and 5:0 keep their value.
- R5: A write to offset 0x07 clears each stored bit that is written as 1 and lies inside mask 0xB0. No bit of that byte is ever set by a write.
- R6: A write to any other offset stores the full data byte. This includes 0x0D, 0x12, 0x13, 0x50-0x78, 0x7E-0x84, 0x88-0x8B, 0xA8-0xAC and 0xFD-0xFF.
- R7: When the bridge-reset event input is high at a clock edge, bits 5:4 of offset 0x63 become 0 and its other bits are kept. If a write to 0x63 occurs in the same cycle, the write is applied first and the clear is applied to its result.
- R8: Reads with function number 0 return the addressed byte in the same cycle. Any other function number reads 0xFF, and writes with a nonzero function number change nothing.
- R9: The mapping-change output is high for exactly the one cycle after an edge at which offset 0x61, 0x62 or 0x63 took a different value. A write of an unchanged value gives no pulse.
- R10: The three shadow outputs always equal the stored bytes at offsets 0x61, 0x62 and 0x63. A write appears on them after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads all reset values |
| brg_rst_evt | input | 1 | Bridge reset event, clears the system-BIOS shadow bits |
| acc_func | input | 3 | Function number of the access |
| acc_off | input | 8 | Byte offset of the access |
| acc_we | input | 1 | Write enable |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the addressed byte |
| shadow_lo | output | 8 | Stored byte at offset 0x61 |
| shadow_mid | output | 8 | Stored byte at offset 0x62 |
| shadow_hi | output | 8 | Stored byte at offset 0x63 |
| map_chg | output | 1 | One-cycle pulse after a shadow byte changes |

## Verification
The assertions assume that the access inputs are stable and known around each rising edge. They also assume that the bridge-reset event is an ordinary synchronous level, so that every state change can be traced to one write or one event at that edge. The bench drives all inputs at the falling edge and holds them through the next rising edge. It reads the addressed byte at the falling edge as well. Writes through the foreign function, and bridge-reset events combined with writes to the same shadow byte, are only applied while the inputs are held stable in this way.

// File: rtl/hb_cfg_pkg.sv
package hb_cfg_pkg;

    localparam int OFF_W   = 8;
    localparam int BYTE_W  = 8;
    localparam int FUNC_W  = 3;
    localparam int N_BYTES = 1 << OFF_W;

    localparam logic [OFF_W-1:0] OFF_CMD    = 8'h04;
    localparam logic [OFF_W-1:0] OFF_STAT   = 8'h07;
    localparam logic [OFF_W-1:0] OFF_SHD0   = 8'h61;
    localparam logic [OFF_W-1:0] OFF_SHD1   = 8'h62;
    localparam logic [OFF_W-1:0] OFF_SHD2   = 8'h63;

    localparam logic [BYTE_W-1:0] CMD_WMASK  = 8'h40;
    localparam logic [BYTE_W-1:0] STAT_W1C   = 8'hB0;
    localparam logic [BYTE_W-1:0] BIOS_SHDW  = 8'h30;
    localparam logic [BYTE_W-1:0] ABSENT_RD  = 8'hFF;

    typedef enum logic [2:0] {
        WR_LOCKED,
        WR_CMDBIT,
        WR_CLR1,
        WR_SHADOW,
        WR_FULL
    } wr_rule_e;

    typedef logic [N_BYTES-1:0][BYTE_W-1:0] cfg_bank_t;

    function automatic logic [BYTE_W-1:0] init_byte(input logic [OFF_W-1:0] a);
        logic [BYTE_W-1:0] v;
        case (a)
            8'h00: v = 8'h06;
            8'h01: v = 8'h11;
            8'h02: v = 8'h85;
            8'h03: v = 8'h05;
            8'h04: v = 8'h07;
            8'h06: v = 8'hA0;
            8'h07: v = 8'h02;
            8'h0B: v = 8'h06;
            8'h58: v = 8'h40;
            8'h59: v = 8'h05;
            8'h5A, 8'h5B, 8'h5C,
            8'h5D, 8'h5E, 8'h5F: v = 8'h01;
            8'h64: v = 8'hAB;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic in_span(input logic [OFF_W-1:0] a,
                                     input logic [OFF_W-1:0] lo,
                                     input logic [OFF_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/hb_cfg_rule.sv
module hb_cfg_rule
    import hb_cfg_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    output wr_rule_e         rule
);
    logic locked;

    always_comb begin
        locked = in_span(off, 8'h00, 8'h03) || in_span(off, 8'h05, 8'h06) ||
                 in_span(off, 8'h08, 8'h0C) || in_span(off, 8'h0E, 8'h11) ||
                 in_span(off, 8'h14, 8'h4F) || in_span(off, 8'h79, 8'h7D) ||
                 in_span(off, 8'h85, 8'h87) || in_span(off, 8'h8C, 8'hA7) ||
                 in_span(off, 8'hAD, 8'hFC);
        if (locked)
            rule = WR_LOCKED;
        else if (off == OFF_CMD)
            rule = WR_CMDBIT;
        else if (off == OFF_STAT)
            rule = WR_CLR1;
        else if (off == OFF_SHD0 || off == OFF_SHD1 || off == OFF_SHD2)
            rule = WR_SHADOW;
        else
            rule = WR_FULL;
    end

endmodule

// File: rtl/hb_cfg_bank.sv
module hb_cfg_bank
    import hb_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [OFF_W-1:0]  off,
    input  logic [BYTE_W-1:0] wdata,
    input  wr_rule_e          rule,
    input  logic              bios_clr,
    output cfg_bank_t         bank,
    output logic              chg_pulse
);
    typedef struct packed {
        cfg_bank_t mem;
        logic      chg;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        logic [BYTE_W-1:0] cur;
        st_d     = st_q;
        st_d.chg = 1'b0;
        cur      = st_q.mem[off];
        if (we) begin
            case (rule)
                WR_CMDBIT: st_d.mem[off] = (cur & ~CMD_WMASK) | (wdata & CMD_WMASK);
                WR_CLR1:   st_d.mem[off] = cur & ~(wdata & STAT_W1C);
                WR_SHADOW,
                WR_FULL:   st_d.mem[off] = wdata;
                default:   st_d.mem[off] = cur;
            endcase
        end
        if (bios_clr)
            st_d.mem[OFF_SHD2] = st_d.mem[OFF_SHD2] & ~BIOS_SHDW;
        st_d.chg = (st_d.mem[OFF_SHD0] != st_q.mem[OFF_SHD0]) ||
                   (st_d.mem[OFF_SHD1] != st_q.mem[OFF_SHD1]) ||
                   (st_d.mem[OFF_SHD2] != st_q.mem[OFF_SHD2]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_BYTES; i++)
                st_q.mem[i] <= init_byte(i[OFF_W-1:0]);
            st_q.chg <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank      = st_q.mem;
    assign chg_pulse = st_q.chg;

    // R3
    identity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable({st_q.mem[0], st_q.mem[1], st_q.mem[2], st_q.mem[3]}));

    // R4
    cmd_other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(st_q.mem[OFF_CMD] & ~CMD_WMASK));

    // R5
    stat_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.mem[OFF_STAT] & ~$past(st_q.mem[OFF_STAT])) == '0));

    // R7
    bios_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bios_clr |=> (st_q.mem[OFF_SHD2][5:4] == 2'b00));

endmodule

// File: rtl/hb_cfg_rdmux.sv
module hb_cfg_rdmux
    import hb_cfg_pkg::*;
(
    input  cfg_bank_t         bank,
    input  logic              fn_ok,
    input  logic [OFF_W-1:0]  off,
    output logic [BYTE_W-1:0] rdata
);
    always_comb begin
        if (fn_ok)
            rdata = bank[off];
        else
            rdata = ABSENT_RD;
    end
endmodule

// File: rtl/hb_cfg_space.sv
module hb_cfg_space
    import hb_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brg_rst_evt,
    input  logic [FUNC_W-1:0] acc_func,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic              acc_we,
    input  logic [BYTE_W-1:0] acc_wdata,
    output logic [BYTE_W-1:0] acc_rdata,
    output logic [BYTE_W-1:0] shadow_lo,
    output logic [BYTE_W-1:0] shadow_mid,
    output logic [BYTE_W-1:0] shadow_hi,
    output logic              map_chg
);
    wr_rule_e  rule;
    cfg_bank_t bank;
    logic      fn_ok;

    assign fn_ok = (acc_func == '0);

    hb_cfg_rule u_rule (
        .off  (acc_off),
        .rule (rule)
    );

    hb_cfg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (acc_we && fn_ok),
        .off       (acc_off),
        .wdata     (acc_wdata),
        .rule      (rule),
        .bios_clr  (brg_rst_evt),
        .bank      (bank),
        .chg_pulse (map_chg)
    );

    hb_cfg_rdmux u_rdmux (
        .bank  (bank),
        .fn_ok (fn_ok),
        .off   (acc_off),
        .rdata (acc_rdata)
    );

    assign shadow_lo  = bank[OFF_SHD0];
    assign shadow_mid = bank[OFF_SHD1];
    assign shadow_hi  = bank[OFF_SHD2];

    // R8
    foreign_fn_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && !fn_ok && !brg_rst_evt) |=> $stable(bank));

    // R9
    pulse_means_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_chg |-> !$stable({shadow_lo, shadow_mid, shadow_hi}));

    // R9
    change_gives_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({shadow_lo, shadow_mid, shadow_hi}) |-> map_chg);

endmodule

// File: tb/hb_cfg_space_tb.sv
module hb_cfg_space_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       brg_rst_evt = 1'b0;
    logic [2:0] acc_func = '0;
    logic [7:0] acc_off = '0;
    logic       acc_we = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata, shadow_lo, shadow_mid, shadow_hi;
    logic       map_chg;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    hb_cfg_space u_dut (
        .clk(clk), .rst_n(rst_n), .brg_rst_evt(brg_rst_evt),
        .acc_func(acc_func), .acc_off(acc_off), .acc_we(acc_we),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .shadow_lo(shadow_lo), .shadow_mid(shadow_mid), .shadow_hi(shadow_hi),
        .map_chg(map_chg)
    );

    typedef struct packed {
        logic [7:0] off;
        logic [7:0] wd;
        logic [7:0] ex;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 8'hFF, 8'h06, 4'd3},  // R3 identity
        '{8'h03, 8'h00, 8'h05, 4'd3},  // R3
        '{8'h05, 8'hFF, 8'h00, 4'd3},  // R3
        '{8'h06, 8'h00, 8'hA0, 4'd3},  // R3
        '{8'h0C, 8'h3C, 8'h00, 4'd3},  // R3
        '{8'h4F, 8'h5A, 8'h00, 4'd3},  // R3
        '{8'h79, 8'h11, 8'h00, 4'd3},  // R3
        '{8'hA7, 8'h22, 8'h00, 4'd3},  // R3
        '{8'hFC, 8'h12, 8'h00, 4'd3},  // R3
        '{8'h04, 8'hFF, 8'h47, 4'd4},  // R4 set bit 6 only
        '{8'h04, 8'h00, 8'h07, 4'd4},  // R4 clear bit 6 only
        '{8'h07, 8'hFF, 8'h02, 4'd5},  // R5 bit 1 outside mask
        '{8'h07, 8'h00, 8'h02, 4'd5},  // R5
        '{8'h58, 8'h3C, 8'h3C, 4'd6},  // R6
        '{8'h0D, 8'h81, 8'h81, 4'd6},  // R6
        '{8'h12, 8'h7E, 8'h7E, 4'd6},  // R6
        '{8'h50, 8'hC3, 8'hC3, 4'd6},  // R6
        '{8'h78, 8'h11, 8'h11, 4'd6},  // R6
        '{8'h7E, 8'hA5, 8'hA5, 4'd6},  // R6
        '{8'h88, 8'h22, 8'h22, 4'd6},  // R6
        '{8'hAC, 8'h9A, 8'h9A, 4'd6},  // R6
        '{8'hFF, 8'h99, 8'h99, 4'd6}   // R6
    };

    function automatic logic [7:0] exp_init(input int a);
        if (a == 0) return 8'h06;
        if (a == 1) return 8'h11;
        if (a == 2) return 8'h85;
        if (a == 3) return 8'h05;
        if (a == 4) return 8'h07;
        if (a == 6) return 8'hA0;
        if (a == 7) return 8'h02;
        if (a == 11) return 8'h06;
        if (a == 'h58) return 8'h40;
        if (a == 'h59) return 8'h05;
        if (a >= 'h5A && a <= 'h5F) return 8'h01;
        if (a == 'h64) return 8'hAB;
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] f, input logic [7:0] o, input logic [7:0] d,
                      input logic evt);
        @(negedge clk);
        acc_func = f; acc_off = o; acc_wdata = d; acc_we = 1'b1; brg_rst_evt = evt;
        @(negedge clk);
        acc_we = 1'b0; brg_rst_evt = 1'b0; acc_func = '0;
    endtask

    task automatic rd(input logic [2:0] f, input logic [7:0] o, output logic [7:0] v);
        acc_func = f; acc_off = o;
        #1;
        v = acc_rdata;
        acc_func = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 and R2: full reset sweep
        for (int a = 0; a < 256; a++) begin
            rd(3'd0, a[7:0], v);
            if (a < 12) chk("R1", v, exp_init(a));
            else        chk("R2", v, exp_init(a));
        end
        chk("R9", {7'd0, map_chg}, 8'h00);

        // table walk: write then read back
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, VEC[i].off, VEC[i].wd, 1'b0);
            rd(3'd0, VEC[i].off, v);
            chk($sformatf("R%0d", VEC[i].req), v, VEC[i].ex);
        end

        // R8: foreign function
        rd(3'd1, 8'h58, v);
        chk("R8", v, 8'hFF);
        rd(3'd7, 8'h00, v);
        chk("R8", v, 8'hFF);
        wr(3'd2, 8'h58, 8'h00, 1'b0);
        rd(3'd0, 8'h58, v);
        chk("R8", v, 8'h3C);
        wr(3'd5, 8'h61, 8'h55, 1'b0);
        chk("R8", shadow_lo, 8'h00);

        // R10 and R9: shadow byte write and pulse
        @(negedge clk);
        acc_off = 8'h61; acc_wdata = 8'hA5; acc_we = 1'b1;
        @(negedge clk);
        acc_we = 1'b0;
        chk("R10", shadow_lo, 8'hA5);
        chk("R9", {7'd0, map_chg}, 8'h01);
        @(negedge clk);
        chk("R9", {7'd0, map_chg}, 8'h00);
        wr(3'd0, 8'h61, 8'hA5, 1'b0);
        chk("R9", {7'd0, map_chg}, 8'h00);
        wr(3'd0, 8'h62, 8'h3C, 1'b0);
        chk("R10", shadow_mid, 8'h3C);
        chk("R9", {7'd0, map_chg}, 8'h01);
        wr(3'd0, 8'h63, 8'hFF, 1'b0);
        chk("R10", shadow_hi, 8'hFF);
        rd(3'd0, 8'h63, v);
        chk("R6", v, 8'hFF);

        // R7: bridge reset event alone
        wr(3'd0, 8'h20, 8'h00, 1'b1);
        chk("R7", shadow_hi, 8'hCF);
        chk("R9", {7'd0, map_chg}, 8'h01);
        // R7: event again, no change, no pulse
        wr(3'd0, 8'h20, 8'h00, 1'b1);
        chk("R7", shadow_hi, 8'hCF);
        chk("R9", {7'd0, map_chg}, 8'h00);
        // R7: event together with write to 0x63
        wr(3'd0, 8'h63, 8'h3A, 1'b1);
        chk("R7", shadow_hi, 8'h0A);
        chk("R10", shadow_lo, 8'hA5);

        // R1: after writes, asynchronous reset restores values
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd0, 8'h04, v);
        chk("R1", v, 8'h07);
        rd(3'd0, 8'h58, v);
        chk("R2", v, 8'h40);
        chk("R10", shadow_hi, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule